// File: doc/BRIEF.md
# Flash program/erase status generator

This block is the device-side status logic of one flash memory bank. When a program or erase command is accepted, the bank becomes busy. While it is busy, a read of the bank returns a status word instead of array contents. Bit 7 of that word tells the host whether the operation is still running. During a program it is the inverse of bit 7 of the data being written. During an erase it is 0. Once the sequencer signals completion, the new array contents read back directly. A separate ready line is low for as long as the bank is busy.

An erase can be suspended. While it is suspended, the bank is ready again and reads of the sectors being erased return 0x80. Reads of any other sector return array data, and those other sectors may be programmed. A resume command restarts the erase. A program to a protected sector does not fail. It holds busy status for a 1 µs window, and an erase whose selected sectors are all protected holds busy status for a 100 µs window. In both cases the bank then returns to array read with nothing changed. Both windows are counted in clock cycles derived from the clock frequency parameter.

A behavioural array stub stands in for the flash cells. It resets to all ones, takes a direct word write when a program completes, and sets whole sectors to all ones when an erase completes. The sector of an address is its top SECT_W bits.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, ready_o is 1 and every address reads 0xFF.
- R2: From the cycle after a program command (cmd_op_i = 0) is accepted in array-read mode, ready_o is 0 and a read at any address returns bit 7 equal to the inverse of cmd_data_i[7], with bits 6..0 equal to 0.
- R3: On the cycle after done_i is seen during a program, ready_o is 1 and the target address reads the programmed word, while every other address is unchanged.
- R4: While an erase runs, ready_o is 0 and every read returns 0x00.
- R5: A sector erase (cmd_op_i = 1) that completes leaves every word of the addressed sector at 0xFF and every other word unchanged.
- R6: A chip erase (cmd_op_i = 2) in which only some sectors are protected erases only the sectors whose prot_mask_i bit is 0.
- R7: When suspend_i is seen during a running erase, the next cycle has ready_o = 1. Reads inside the sectors being erased then return 0x80, and reads elsewhere return array data. suspend_i has no effect during a program.
- R8: While an erase is suspended, a program to a sector that is not being erased reports status as in R2 and returns to the suspended state when done. A program to a sector that is being erased is ignored. A resume command (cmd_op_i = 3) restarts the erase as in R4.
- R9: A program to a protected sector keeps ready_o at 0 for exactly CLK_FREQ_HZ/1e6 cycles, with status as in R2, and ignores done_i. The bank then reads the target word unchanged.
- R10: An erase whose selected sectors are all protected keeps ready_o at 0 for exactly CLK_FREQ_HZ/1e4 cycles with reads of 0x00. The array is unchanged afterwards.
- R11: Commands seen while ready_o is 0 are ignored. Erase commands seen during erase-suspend are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Strobe marking the final write of a command sequence |
| cmd_op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 resume |
| cmd_addr_i | input | ADDR_W | Target address (sector = top SECT_W bits) |
| cmd_data_i | input | DATA_W | Word to program |
| prot_mask_i | input | 2**SECT_W | Per-sector protection, 1 = protected |
| done_i | input | 1 | Completion pulse from the operation sequencer |
| suspend_i | input | 1 | Erase suspend request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data or status word |
| ready_o | output | 1 | High when no operation is in progress |

## Verification
The hardest state to reach is a program that runs inside a suspended erase. To get there, the bench first writes known data into the sector that will be erased and then starts a sector erase. It raises suspend_i and, with the erase suspended, issues programs to a foreign sector and to the suspended sector itself. Around these, it checks that reads of the erased sector keep showing 0x80, that the foreign word lands, and that a resume brings the 0x00 erase status back. The two protection windows are measured edge by edge: ready_o must still be 0 on the last counted cycle and 1 on the next, and done_i is held high through the program window.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE, ST_PROT, ST_SUSP, ST_SPROG
  } fsg_state_e;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0, OP_SERASE = 2'd1, OP_CERASE = 2'd2, OP_RESUME = 2'd3
  } fsg_op_e;
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import flash_status_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 3,
  parameter int CNT_W     = 14,
  parameter int PROG_CYC  = 125,
  parameter int ERASE_CYC = 12500,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [DATA_W-1:0]   cmd_data_i,
  input  logic [NUM_SECT-1:0] prot_mask_i,
  input  logic                done_i,
  input  logic                suspend_i,
  output fsg_state_e          st_o,
  output logic [ADDR_W-1:0]   tgt_addr_o,
  output logic [DATA_W-1:0]   tgt_data_o,
  output logic [NUM_SECT-1:0] esel_o,
  output logic                win_prog_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                wr_en_o,
  output logic                er_en_o
);
  fsg_state_e          st_q, st_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   data_q, data_d;
  logic [NUM_SECT-1:0] esel_q, esel_d;
  logic                win_prog_q, win_prog_d;
  logic                ret_susp_q, ret_susp_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  logic [SECT_W-1:0]   cmd_sect;
  logic [NUM_SECT-1:0] cmd_oh;
  logic                prot_hit;
  fsg_op_e             op;

  assign cmd_sect = cmd_addr_i[ADDR_W-1 -: SECT_W];
  assign cmd_oh   = NUM_SECT'(1) << cmd_sect;
  assign prot_hit = prot_mask_i[cmd_sect];
  assign op       = fsg_op_e'(cmd_op_i);

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    data_d     = data_q;
    esel_d     = esel_q;
    win_prog_d = win_prog_q;
    ret_susp_d = ret_susp_q;
    cnt_d      = cnt_q;
    wr_en_o    = 1'b0;
    er_en_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid_i) begin
        unique case (op)
          OP_PROG: begin
            addr_d     = cmd_addr_i;
            data_d     = cmd_data_i;
            ret_susp_d = 1'b0;
            if (prot_hit) begin
              st_d       = ST_PROT;
              win_prog_d = 1'b1;
              cnt_d      = CNT_W'(PROG_CYC - 1);
            end else begin
              st_d = ST_PROG;
            end
          end
          OP_SERASE: begin
            addr_d     = cmd_addr_i;
            ret_susp_d = 1'b0;
            win_prog_d = 1'b0;
            if (prot_hit) begin
              st_d  = ST_PROT;
              cnt_d = CNT_W'(ERASE_CYC - 1);
            end else begin
              st_d   = ST_ERASE;
              esel_d = cmd_oh;
            end
          end
          OP_CERASE: begin
            ret_susp_d = 1'b0;
            win_prog_d = 1'b0;
            if (&prot_mask_i) begin
              st_d  = ST_PROT;
              cnt_d = CNT_W'(ERASE_CYC - 1);
            end else begin
              st_d   = ST_ERASE;
              esel_d = ~prot_mask_i;
            end
          end
          default: ;
        endcase
      end
      ST_PROG: if (done_i) begin
        wr_en_o = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_ERASE: begin
        if (done_i) begin
          er_en_o = 1'b1;
          st_d    = ST_IDLE;
        end else if (suspend_i) begin
          st_d = ST_SUSP;
        end
      end
      ST_PROT: begin
        if (cnt_q == '0) st_d = ret_susp_q ? ST_SUSP : ST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_SUSP: if (cmd_valid_i) begin
        // only sectors outside the suspended erase may be programmed
        if (op == OP_PROG && !esel_q[cmd_sect]) begin
          addr_d = cmd_addr_i;
          data_d = cmd_data_i;
          if (prot_hit) begin
            st_d       = ST_PROT;
            win_prog_d = 1'b1;
            ret_susp_d = 1'b1;
            cnt_d      = CNT_W'(PROG_CYC - 1);
          end else begin
            st_d = ST_SPROG;
          end
        end else if (op == OP_RESUME) begin
          st_d = ST_ERASE;
        end
      end
      ST_SPROG: if (done_i) begin
        wr_en_o = 1'b1;
        st_d    = ST_SUSP;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      esel_q     <= '0;
      win_prog_q <= 1'b0;
      ret_susp_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      st_q       <= st_d;
      addr_q     <= addr_d;
      data_q     <= data_d;
      esel_q     <= esel_d;
      win_prog_q <= win_prog_d;
      ret_susp_q <= ret_susp_d;
      cnt_q      <= cnt_d;
    end
  end

  assign st_o       = st_q;
  assign tgt_addr_o = addr_q;
  assign tgt_data_o = data_q;
  assign esel_o     = esel_q;
  assign win_prog_o = win_prog_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/fsg_array.sv
module fsg_array #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 3,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                er_en_i,
  input  logic [NUM_SECT-1:0] esel_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WPS   = DEPTH / NUM_SECT;

  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [SECT_W-1:0] SIDX  = SECT_W'(g / WPS);
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(g);
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             word_q <= '1;
      else if (er_en_i && esel_i[SIDX])        word_q <= '1;
      else if (wr_en_i && wr_addr_i == WADDR)  word_q <= wr_data_i;
    end
    assign words[g] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/fsg_rdmux.sv
module fsg_rdmux
  import flash_status_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 3,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  fsg_state_e          st_i,
  input  logic                tgt_msb_i,
  input  logic                win_prog_i,
  input  logic [NUM_SECT-1:0] esel_i,
  input  logic [SECT_W-1:0]   rd_sect_i,
  input  logic [DATA_W-1:0]   arr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                ready_o
);
  localparam logic [DATA_W-2:0] LOW_ZERO = '0;

  always_comb begin
    unique case (st_i)
      ST_PROG, ST_SPROG: rd_data_o = {~tgt_msb_i, LOW_ZERO};
      ST_PROT:           rd_data_o = {win_prog_i & ~tgt_msb_i, LOW_ZERO};
      ST_ERASE:          rd_data_o = '0;
      ST_SUSP:           rd_data_o = esel_i[rd_sect_i] ? {1'b1, LOW_ZERO} : arr_data_i;
      default:           rd_data_o = arr_data_i;
    endcase
  end

  assign ready_o = (st_i == ST_IDLE) || (st_i == ST_SUSP);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SECT_W      = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic [1:0]               cmd_op_i,
  input  logic [ADDR_W-1:0]        cmd_addr_i,
  input  logic [DATA_W-1:0]        cmd_data_i,
  input  logic [(1<<SECT_W)-1:0]   prot_mask_i,
  input  logic                     done_i,
  input  logic                     suspend_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     ready_o
);
  localparam int NUM_SECT  = 1 << SECT_W;
  localparam int PROG_CYC  = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;
  localparam int ERASE_CYC = (CLK_FREQ_HZ / 10_000 < 1) ? 1 : CLK_FREQ_HZ / 10_000;
  localparam int CNT_W     = $clog2(ERASE_CYC + 1);

  fsg_state_e          st;
  logic [ADDR_W-1:0]   tgt_addr;
  logic [DATA_W-1:0]   tgt_data;
  logic [NUM_SECT-1:0] esel;
  logic                win_prog;
  logic [CNT_W-1:0]    win_cnt;
  logic                wr_en, er_en;
  logic [DATA_W-1:0]   arr_data;

  fsg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_data_i,
    .prot_mask_i, .done_i, .suspend_i,
    .st_o(st), .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data), .esel_o(esel),
    .win_prog_o(win_prog), .cnt_o(win_cnt), .wr_en_o(wr_en), .er_en_o(er_en)
  );

  fsg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) i_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(tgt_addr), .wr_data_i(tgt_data),
    .er_en_i(er_en), .esel_i(esel), .rd_addr_i, .rd_data_o(arr_data)
  );

  fsg_rdmux #(.DATA_W(DATA_W), .SECT_W(SECT_W)) i_rdmux (
    .st_i(st), .tgt_msb_i(tgt_data[DATA_W-1]), .win_prog_i(win_prog), .esel_i(esel),
    .rd_sect_i(rd_addr_i[ADDR_W-1 -: SECT_W]), .arr_data_i(arr_data),
    .rd_data_o, .ready_o
  );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [DATA_W-1:0] cmd_data_i,
  input logic              done_i,
  input logic              suspend_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ready_o,
  input fsg_state_e        st_i,
  input logic [CNT_W-1:0]  cnt_i
);
  assert_prog_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && cmd_valid_i && cmd_op_i == 2'd0)
    |=> (!ready_o && rd_data_o[DATA_W-1] != $past(cmd_data_i[DATA_W-1])));

  assert_prog_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PROG && done_i) |=> (ready_o && st_i == ST_IDLE));

  assert_erase_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ERASE) |-> (rd_data_o == '0 && !ready_o));

  assert_suspend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ERASE && suspend_i && !done_i) |=> (ready_o && st_i == ST_SUSP));

  assert_window_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PROT && cnt_i == '0) |=> ready_o);

  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PROG && !done_i) |=> (st_i == ST_PROG));
endmodule

bind flash_status_gen flash_status_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_data_i, .done_i, .suspend_i,
  .rd_data_o, .ready_o, .st_i(st), .cnt_i(win_cnt)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int AW = 5, DW = 8, SW = 2, WPS = 8, DEPTH = 32;
  localparam int FHZ = 8_000_000, PW = 8, EW = 800;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni, cmd_valid, done, suspend, ready;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [DW-1:0] cmd_data, rd_data;
  logic [3:0]    prot_mask;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] mdl [DEPTH];

  flash_status_gen #(.CLK_FREQ_HZ(FHZ), .ADDR_W(AW), .DATA_W(DW), .SECT_W(SW))
  i_flash_status_gen (
    .clk_i(clk), .rst_ni, .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .prot_mask_i(prot_mask),
    .done_i(done), .suspend_i(suspend), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .ready_o(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
    rd_addr = AW'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic rdy_chk(input string req, input logic exp);
    chk(req, {7'b0, ready}, {7'b0, exp});
  endtask

  task automatic all_chk(input string req);
    for (int a = 0; a < DEPTH; a++) rd_chk(req, a, mdl[a]);
  endtask

  task automatic cmd(input logic [1:0] op, input int a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic done_pulse;
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic erase_model(input int s);
    for (int a = s * WPS; a < (s + 1) * WPS; a++) mdl[a] = 8'hFF;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    prot_mask = '0; done = 1'b0; suspend = 1'b0; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rdy_chk("R1", 1'b1);
    all_chk("R1");

    // R2/R3 program sweep over every address
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d;
      d = 8'(a * 53 + 17);
      cmd(2'd0, a, d);
      rdy_chk("R2", 1'b0);
      rd_chk("R2", a, {~d[7], 7'b0});
      rd_chk("R2", a ^ 5, {~d[7], 7'b0});
      done_pulse();
      mdl[a] = d;
      rdy_chk("R3", 1'b1);
      rd_chk("R3", a, d);
    end
    all_chk("R3");

    // R11 erase while program busy ignored; R7 suspend ignored in program
    cmd(2'd0, 0, 8'h11);
    cmd(2'd1, 0, 8'h00);
    @(negedge clk); suspend = 1'b1;
    @(negedge clk); suspend = 1'b0;
    rdy_chk("R7", 1'b0);
    rd_chk("R11", 3, 8'h80);
    done_pulse();
    mdl[0] = 8'h11;
    rdy_chk("R11", 1'b1);
    all_chk("R11");

    // R4/R5 sector erase of sector 1
    cmd(2'd1, 11, 8'h00);
    rdy_chk("R4", 1'b0);
    rd_chk("R4", 11, 8'h00);
    rd_chk("R4", 2, 8'h00);
    done_pulse();
    erase_model(1);
    rdy_chk("R5", 1'b1);
    all_chk("R5");

    // R6 chip erase, sectors 0 and 2 protected
    prot_mask = 4'b0101;
    cmd(2'd2, 0, 8'h00);
    rd_chk("R6", 30, 8'h00);
    done_pulse();
    erase_model(1); erase_model(3);
    all_chk("R6");
    prot_mask = '0;

    // R7/R8 suspend, program inside suspend, resume
    cmd(2'd0, 9, 8'h3C); done_pulse(); mdl[9] = 8'h3C;
    cmd(2'd1, 9, 8'h00);
    rd_chk("R4", 9, 8'h00);
    @(negedge clk); suspend = 1'b1;
    @(negedge clk); suspend = 1'b0;
    rdy_chk("R7", 1'b1);
    rd_chk("R7", 9, 8'h80);
    rd_chk("R7", 15, 8'h80);
    rd_chk("R7", 2, mdl[2]);
    cmd(2'd2, 0, 8'h00);
    rdy_chk("R11", 1'b1);
    rd_chk("R11", 2, mdl[2]);
    cmd(2'd0, 20, 8'h5A);
    rdy_chk("R8", 1'b0);
    rd_chk("R8", 20, 8'h80);
    done_pulse();
    mdl[20] = 8'h5A;
    rdy_chk("R8", 1'b1);
    rd_chk("R8", 20, 8'h5A);
    rd_chk("R8", 9, 8'h80);
    cmd(2'd0, 10, 8'h00);
    rdy_chk("R8", 1'b1);
    rd_chk("R8", 10, 8'h80);
    cmd(2'd3, 0, 8'h00);
    rdy_chk("R8", 1'b0);
    rd_chk("R8", 9, 8'h00);
    done_pulse();
    erase_model(1);
    all_chk("R8");

    // R9 protected program window, done_i held high and ignored
    prot_mask = 4'b1000;
    cmd(2'd0, 30, 8'h7E);
    done = 1'b1;
    rd_chk("R9", 30, 8'h80);
    repeat (PW - 1) @(negedge clk);
    rdy_chk("R9", 1'b0);
    done = 1'b0;
    @(negedge clk);
    rdy_chk("R9", 1'b1);
    rd_chk("R9", 30, mdl[30]);

    // R10 protected sector erase window
    prot_mask = 4'b0010;
    cmd(2'd1, 12, 8'h00);
    rd_chk("R10", 12, 8'h00);
    repeat (EW - 1) @(negedge clk);
    rdy_chk("R10", 1'b0);
    @(negedge clk);
    rdy_chk("R10", 1'b1);
    all_chk("R10");

    // R10 chip erase with every sector protected
    prot_mask = 4'b1111;
    cmd(2'd2, 0, 8'h00);
    repeat (EW - 1) @(negedge clk);
    rdy_chk("R10", 1'b0);
    @(negedge clk);
    rdy_chk("R10", 1'b1);
    all_chk("R10");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule